// File: doc/BRIEF.md
# Transmit FFE Tap-Weight Combiner

This block turns a serial bit stream into a signed drive weight per bit time for a three-tap transmit feed-forward equalizer. A fixed pool of 48 identical drive units is divided between a main cursor, a pre-cursor that acts on the following bit and a post-cursor that acts on the preceding bit. Any unit not claimed by a side tap is given back to the main cursor, so the pool is always fully in use. The weight for each bit is the sum of the three tap contributions, scaled by an amplitude code. The analog driver that turns this weight into a voltage is downstream.

Bits enter with a valid strobe, one per clock. The weight for a bit can only be formed once the next bit is known, so each result is one clock later than its bit. Equalization type, tap signs, tap unit counts and amplitude code are captured only while the block is idle. A change to these inputs during a stream has no effect until the stream ends.

Top module: `tx_ffe_combiner`

## Requirements
- R1: The pre-cursor gets min(pre_units, 12) units in three-tap mode and 0 otherwise. The post-cursor gets min(post_units, 16) units in two-tap and three-tap mode and 0 with no equalization. The main cursor gets 48 minus both, so |drive_out| never exceeds 48.
- R2: With eq_mode 00 (no equalization), all 48 units go to the main cursor, and each valid output is +48 or -48 times the amplitude factor, whatever the tap inputs are.
- R3: With eq_mode 01 (two-tap), pre_units and pre_sub have no effect on the output.
- R4: With eq_mode 10 or 11 (three-tap), a bit maps to s=+1 for 1 and s=-1 for 0. The output is main*s(t) - pre*s(t+1) - post*s(t-1) when both sub bits are 1. With pre 3 and post 10 this gives ±48 for alternating bits, ±22 inside runs, and ±28 or ±42 for mixed neighbours.
- R5: A tap whose sub bit is 0 adds its neighbour term (+units*s) instead of subtracting it.
- R6: A neighbour that is not part of the same unbroken run of valid bits contributes nothing. This covers the bit before the first bit, the bit after the last bit, and bits across a one-cycle gap.
- R7: The weight for a bit accepted at clock edge k appears on drive_out with out_valid high after edge k+1. When out_valid is low, drive_out is 0.
- R8: The summed weight is multiplied by (8 - amp_code)/8 and rounded toward zero. amp_code 0 means full amplitude.
- R9: Configuration inputs are captured only at an edge where in_valid is low and no accepted bit is waiting for its result. Changes at any other edge are ignored.
- R10: Reset clears out_valid and drive_out and loads the default configuration: no equalization and full amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eq_mode | input | 2 | 00 none, 01 two-tap, 1x three-tap |
| pre_sub | input | 1 | Pre-cursor subtracts the next bit's term when 1 |
| pre_units | input | 5 | Requested pre-cursor units (saturates at 12) |
| post_sub | input | 1 | Post-cursor subtracts the previous bit's term when 1 |
| post_units | input | 5 | Requested post-cursor units (saturates at 16) |
| amp_code | input | 3 | Amplitude factor (8 - code)/8 |
| in_valid | input | 1 | in_bit holds a stream bit this cycle |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | drive_out holds a bit weight |
| drive_out | output | 8 | Signed drive weight |

## Verification
Some properties are checked by assertions on every cycle:
- the one-edge result latency and the zero output when idle;
- the saturated unit counts and the ±48 bound;
- configuration held steady whenever a bit is arriving;
- the full-swing result whenever all units sit on the main cursor.

The exact sums cannot be checked that way, because they depend on patterns and neighbours. The bench scenarios check them against a separate model, covering:
- each mode and both tap signs;
- rounding toward zero for negative weights;
- neighbours dropped at run edges and across gaps;
- configuration changes made mid-stream and the configuration in force right after reset.

// File: rtl/tx_ffe_combiner.sv
module tx_ffe_combiner #(
  parameter int TOTAL_UNITS = 48,
  parameter int PRE_MAX     = 12,
  parameter int POST_MAX    = 16,
  parameter int CNT_W       = 5,
  parameter int AMP_W       = 3,
  parameter int OUT_W       = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              eq_mode,
  input  logic                    pre_sub,
  input  logic [CNT_W-1:0]        pre_units,
  input  logic                    post_sub,
  input  logic [CNT_W-1:0]        post_units,
  input  logic [AMP_W-1:0]        amp_code,
  input  logic                    in_valid,
  input  logic                    in_bit,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] drive_out
);

  localparam int UW    = $clog2(TOTAL_UNITS + 1);
  localparam int SCALE = 1 << AMP_W;
  localparam int PW    = $clog2(TOTAL_UNITS * SCALE + 1) + 1;

  logic [UW-1:0]    pre_lim, post_lim;
  logic [UW-1:0]    pre_q, post_q, main_q;
  logic             pre_sub_q, post_sub_q;
  logic [AMP_W-1:0] amp_q;
  logic             cur_vld, cur_bit, prv_vld, prv_bit;
  logic             idle;
  logic signed [PW-1:0] t_main, t_pre, t_post, sum, gain, prod, mag, shrunk;

  function automatic logic signed [PW-1:0] signed_w(input logic pos, input logic [UW-1:0] w);
    logic signed [PW-1:0] v;
    v = $signed(PW'(w));
    return pos ? v : -v;
  endfunction

  assign idle = !in_valid && !cur_vld;

  assign pre_lim  = !eq_mode[1] ? '0 :
                    (int'(pre_units) > PRE_MAX) ? UW'(PRE_MAX) : UW'(pre_units);
  assign post_lim = (eq_mode == 2'b00) ? '0 :
                    (int'(post_units) > POST_MAX) ? UW'(POST_MAX) : UW'(post_units);

  assign t_main = signed_w(cur_bit, main_q);
  assign t_pre  = in_valid ? signed_w(in_bit ^ pre_sub_q, pre_q) : '0;
  assign t_post = prv_vld ? signed_w(prv_bit ^ post_sub_q, post_q) : '0;
  assign sum    = t_main + t_pre + t_post;

  assign gain   = $signed(PW'(SCALE - int'(amp_q)));
  assign prod   = sum * gain;
  assign mag    = prod[PW-1] ? -prod : prod;
  assign shrunk = prod[PW-1] ? -(mag >>> AMP_W) : (mag >>> AMP_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      post_q     <= '0;
      main_q     <= UW'(TOTAL_UNITS);
      pre_sub_q  <= 1'b0;
      post_sub_q <= 1'b0;
      amp_q      <= '0;
      cur_vld    <= 1'b0;
      cur_bit    <= 1'b0;
      prv_vld    <= 1'b0;
      prv_bit    <= 1'b0;
      out_valid  <= 1'b0;
      drive_out  <= '0;
    end else begin
      if (idle) begin
        pre_q      <= pre_lim;
        post_q     <= post_lim;
        main_q     <= UW'(TOTAL_UNITS) - pre_lim - post_lim;
        pre_sub_q  <= pre_sub;
        post_sub_q <= post_sub;
        amp_q      <= amp_code;
      end
      prv_vld   <= cur_vld;
      prv_bit   <= cur_bit;
      cur_vld   <= in_valid;
      cur_bit   <= in_bit;
      out_valid <= cur_vld;
      drive_out <= cur_vld ? shrunk[OUT_W-1:0] : '0;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (drive_out == 0));

  p_pool_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pre_q) <= PRE_MAX) && (int'(post_q) <= POST_MAX));

  p_swing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((drive_out <= TOTAL_UNITS) && (drive_out >= -TOTAL_UNITS)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $stable({pre_q, post_q, main_q, pre_sub_q, post_sub_q, amp_q}));

  p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (int'($past(main_q)) == TOTAL_UNITS) && ($past(amp_q) == 0))
      |-> ((drive_out == TOTAL_UNITS) || (drive_out == -TOTAL_UNITS)));

endmodule

// File: tb/tx_ffe_combiner_bench.sv
module tx_ffe_combiner_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] eq_mode = 2'b00;
  logic pre_sub = 1'b0, post_sub = 1'b0;
  logic [4:0] pre_units = '0, post_units = '0;
  logic [2:0] amp_code = '0;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic out_valid;
  logic signed [7:0] drive_out;

  tx_ffe_combiner u_tx_ffe_combiner (
    .clk(clk), .rst_n(rst_n), .eq_mode(eq_mode), .pre_sub(pre_sub),
    .pre_units(pre_units), .post_sub(post_sub), .post_units(post_units),
    .amp_code(amp_code), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .drive_out(drive_out));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  int vin [64];
  int bin [64];
  int n;
  int m_mode, m_pre, m_post, m_ps, m_qs, m_amp;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sv(input int b);
    return b ? 1 : -1;
  endfunction

  function automatic int exp_w(input int i);
    int pe, qe, me, s, p;
    pe = (m_mode >= 2) ? ((m_pre > 12) ? 12 : m_pre) : 0;
    qe = (m_mode != 0) ? ((m_post > 16) ? 16 : m_post) : 0;
    me = 48 - pe - qe;
    s = me * sv(bin[i]);
    if (i + 1 < n && vin[i+1] != 0) s += (m_ps ? -1 : 1) * pe * sv(bin[i+1]);
    if (i > 0 && vin[i-1] != 0)     s += (m_qs ? -1 : 1) * qe * sv(bin[i-1]);
    p = s * (8 - m_amp);
    return (p < 0) ? -((-p) / 8) : p / 8;
  endfunction

  task automatic load(input logic [63:0] pat, input int len);
    n = len;
    for (int i = 0; i < 64; i++) begin
      vin[i] = (i < len) ? 1 : 0;
      bin[i] = (i < len) ? int'(pat[len-1-i]) : 0;
    end
  endtask

  task automatic apply_cfg(input int md, input int pu, input int qu,
                           input int ps, input int qs, input int am);
    @(negedge clk);
    in_valid = 0;
    eq_mode = 2'(md); pre_units = 5'(pu); post_units = 5'(qu);
    pre_sub = ps[0]; post_sub = qs[0]; amp_code = 3'(am);
    m_mode = md; m_pre = pu; m_post = qu; m_ps = ps; m_qs = qs; m_amp = am;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input string req, input int swap_at);
    for (int i = 0; i <= n + 1; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        if (vin[i-2] != 0) begin
          chk({req, " valid"}, int'(out_valid), 1);
          chk({req, " weight"}, int'(drive_out), exp_w(i-2));
        end else begin
          chk({req, " gap valid R7"}, int'(out_valid), 0);
          chk({req, " gap weight R7"}, int'(drive_out), 0);
        end
      end
      if (i == swap_at) begin
        eq_mode = 2'b10; pre_units = 5'd7; post_units = 5'd2;
        pre_sub = ~pre_sub; post_sub = ~post_sub; amp_code = 3'd6;
      end
      if (i < n) begin
        in_valid = vin[i][0]; in_bit = bin[i][0];
      end else begin
        in_valid = 0;
      end
    end
    @(negedge clk);
    chk({req, " drained R7"}, int'(out_valid), 0);
    chk({req, " drained weight R7"}, int'(drive_out), 0);
  endtask

  task automatic t_reset;
    eq_mode = 2'b10; pre_units = 5'd3; post_units = 5'd10;
    pre_sub = 1; post_sub = 1; amp_code = 3'd4;
    in_valid = 1; in_bit = 1;
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", int'(out_valid), 0);
    chk("R10 reset weight", int'(drive_out), 0);
    rst_n = 1;
    @(negedge clk);
    in_bit = 0;
    @(negedge clk);
    in_valid = 0;
    chk("R10 default cfg valid", int'(out_valid), 1);
    chk("R10 default cfg weight", int'(drive_out), 48);
    @(negedge clk);
    chk("R10 default cfg weight 2", int'(drive_out), -48);
    @(negedge clk);
    chk("R10 idle after", int'(out_valid), 0);
  endtask

  task automatic t_none;
    apply_cfg(0, 3, 10, 1, 1, 0);
    load(64'b00111110101100000101, 20);
    run("R2 no equalization", -1);
  endtask

  task automatic t_two_tap;
    apply_cfg(1, 7, 10, 1, 1, 0);
    load(64'b00111110101100000101, 20);
    run("R3 two-tap pre ignored", -1);
  endtask

  task automatic t_three_tap;
    apply_cfg(2, 3, 10, 1, 1, 0);
    load(64'b00111110101100000101, 20);
    run("R4 three-tap", -1);
    load(64'b0101010111, 10);
    run("R4 three-tap alternating and run", -1);
  endtask

  task automatic t_sign_zero;
    apply_cfg(3, 4, 6, 0, 0, 0);
    load(64'b0011010001110, 13);
    run("R5 sub bits zero", -1);
    apply_cfg(2, 5, 9, 1, 0, 0);
    load(64'b1101001110, 10);
    run("R5 mixed sub bits", -1);
  endtask

  task automatic t_saturate;
    apply_cfg(2, 31, 20, 1, 1, 0);
    load(64'b1110101100, 10);
    run("R1 saturated counts", -1);
  endtask

  task automatic t_amp;
    apply_cfg(2, 3, 10, 1, 1, 3);
    load(64'b00111110101100000101, 20);
    run("R8 amplitude code 3", -1);
    apply_cfg(2, 3, 10, 1, 1, 7);
    load(64'b00111110101100000101, 20);
    run("R8 amplitude code 7", -1);
  endtask

  task automatic t_gap_hold;
    apply_cfg(1, 0, 8, 1, 1, 0);
    load(64'b110100111001, 12);
    vin[5] = 0;
    run("R6 gap splits neighbours", -1);
    load(64'b1, 1);
    run("R6 lone bit", -1);
    apply_cfg(2, 3, 10, 1, 1, 0);
    load(64'b01100101110100, 14);
    run("R9 mid-stream change ignored", 6);
    apply_cfg(2, 3, 10, 1, 1, 0);
    load(64'b0110, 4);
    run("R9 reconfigured after idle", -1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_none();
    t_two_tap();
    t_three_tap();
    t_sign_zero();
    t_saturate();
    t_amp();
    t_gap_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule